// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. Commands, addresses and byte enables are sampled on the rising clock edge. Write data follows its command by a fixed late-write distance. In pipelined mode that distance is two edges and read data leaves through an output register. In flow-through mode the distance is one edge and read data is driven straight from the array. Because of this, a read can follow a write and a write can follow a read on every cycle.

A four-beat burst engine steps the two low address bits in linear or interleaved order while an advance input is held. Three chip enables must all be high to start a command, so several copies can be stacked in depth. An asynchronous output enable and an asynchronous sleep input can turn off the data drive at any time. Sleep also blocks new commands.

The array is a small register memory. It is written 9 bits at a time under per-byte enables. A pipelined read of a word whose late write data lands on the same edge returns the merged new contents.

Top module: `zbt_sram_core`

## Requirements
- R1: A new command starts at an edge only when `chip_en` is 3'b111, `adv` is 0 and `sleep` is 0. `wr_en`=1 selects a write and 0 selects a read. If `adv` is 0 and any chip enable is low, the cycle is a deselect: nothing is written and no read data is driven for it.
- R2: In flow-through mode (`pipe_mode`=0), a read started at edge N drives `dq_oe`=1 and the addressed word on `dq_out` between edges N and N+1.
- R3: In pipelined mode (`pipe_mode`=1), a read started at edge N drives `dq_oe`=1 and the addressed word between edges N+1 and N+2.
- R4: The data of a write started at edge N is taken from `wdata` at edge N+2 in pipelined mode and at edge N+1 in flow-through mode. A flow-through read started at edge N+1 to the same word returns the new data.
- R5: Byte b occupies `wdata`/`dq_out` bits [9b+8:9b]. Only bytes whose `byte_we[b]` was 1 in the cycle the write beat was issued are changed.
- R6: With `burst_il`=0, each advance beat k (k=1..3, wrapping) uses low address bits (start+k) mod 4. The upper address bits are kept.
- R7: With `burst_il`=1, each advance beat k uses low address bits start XOR k. The upper address bits are kept.
- R8: With `adv`=1 and `sleep`=0, the last command's read or write continues with the next burst beat, regardless of the chip enables. If no burst is active (after reset or a deselect), `adv`=1 does nothing.
- R9: In pipelined mode, a read whose address matches a write whose data arrives on the read's output-register edge returns the array word merged with that data, byte by byte.
- R10: When `out_en` is 0, `dq_oe` is 0 at once, with no clock edge needed.
- R11: While `sleep` is 1, `dq_oe` is 0 and commands and advances presented at an edge are ignored. The burst state is held.
- R12: After synchronous reset, `dq_oe` is 0, no burst is active and every word reads as 0.
- R13: Reads and writes can alternate on consecutive cycles with no deselect between them, and every read returns the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_il | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sleep | input | 1 | Asynchronous power-down request |
| out_en | input | 1 | Asynchronous output drive enable |
| chip_en | input | 3 | Chip enables, all must be 1 to start a command |
| adv | input | 1 | Continue the current burst |
| wr_en | input | 1 | 1 write, 0 read for a new command |
| addr | input | ADDR_W | Word address of a new command |
| byte_we | input | NBYTES | Per-byte write enables of a write beat |
| wdata | input | NBYTES*BYTE_W | Late write data bus |
| dq_out | output | NBYTES*BYTE_W | Read data |
| dq_oe | output | 1 | High while `dq_out` carries valid driven read data |

## Verification
A fixed-seed random stream mixes reads, writes, advances, partial chip enables, random byte masks, and occasional sleep and output-enable drops. It runs in all four combinations of mode and burst order, so the late-write distance, the read latency and the address sequence are each tested against the others. Directed read-after-write sequences separate the two write distances. A write followed at once by a read of the same word in pipelined mode can only pass through forwarding. Bursts that start at a nonzero low address expose the difference between the linear and interleaved orders. Chip-enable, sleep and advance-without-burst cases confirm that the cycle leaves the data and the drive untouched.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BURST_BITS   = 2;
    localparam int DEF_NBYTES   = 4;
    localparam int DEF_BYTE_W   = 9;
    localparam int DEF_ADDR_W   = 5;

    typedef logic [BURST_BITS-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } op_e;

    // low address bits of a burst beat
    function automatic beat_t burst_lo(beat_t start, beat_t n, logic il);
        beat_t r;
        if (il) r = start ^ n;
        else    r = beat_t'(start + n);
        return r;
    endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
    import zbt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              burst_il,
    input  logic [2:0]        chip_en,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_kind,
    output logic [ADDR_W-1:0] op_addr
);

    logic              active;
    op_e               held_kind;
    logic [ADDR_W-1:0] base;
    beat_t             beat;
    beat_t             nxt_beat;
    logic              cont;
    logic              load;

    assign cont     = !sleep && adv && active;
    assign load     = !sleep && !adv && (&chip_en);
    assign nxt_beat = beat_t'(beat + 1'b1);

    always_comb begin
        op_kind = OP_IDLE;
        op_addr = '0;
        if (cont) begin
            op_kind = held_kind;
            op_addr = {base[ADDR_W-1:BURST_BITS],
                       burst_lo(base[BURST_BITS-1:0], nxt_beat, burst_il)};
        end else if (load) begin
            op_kind = wr_en ? OP_WRITE : OP_READ;
            op_addr = addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            held_kind <= OP_IDLE;
            base      <= '0;
            beat      <= '0;
        end else if (cont) begin
            beat <= nxt_beat;
        end else if (load) begin
            active    <= 1'b1;
            held_kind <= wr_en ? OP_WRITE : OP_READ;
            base      <= addr;
            beat      <= '0;
        end else if (!sleep && !adv) begin
            active <= 1'b0;
        end
    end

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adv && active) |=> (beat == beat_t'($past(beat) + 1'b1))) // R8
        else $error("burst beat did not step");

    AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adv && (&chip_en)) |=> (active && beat == '0)) // R1
        else $error("new command did not restart burst");

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(beat) && $stable(active))) // R11
        else $error("burst state moved while asleep");

endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = DEF_NBYTES,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int DATA_W = NBYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTES-1:0] wr_bwe,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_fwd
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_go) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_bwe[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rd_word = mem[rd_addr];

    // merge of a write landing on this very edge
    always_comb begin
        rd_fwd = rd_word;
        if (wr_go && (wr_addr == rd_addr)) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_bwe[b]) rd_fwd[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_go && (&wr_bwe)) |=> (mem[$past(wr_addr)] == $past(wr_data))) // R4
        else $error("full write did not land");

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int NBYTES = DEF_NBYTES,
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_mode,
    input  logic              burst_il,
    input  logic              sleep,
    input  logic              out_en,
    input  logic [2:0]        chip_en,
    input  logic              adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    op_e               op_kind;
    logic [ADDR_W-1:0] op_addr;

    op_e               s1_kind, s2_kind;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s1_bwe,  s2_bwe;

    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [NBYTES-1:0] commit_bwe;
    logic [DATA_W-1:0] rd_word, rd_fwd;

    logic [DATA_W-1:0] out_q;
    logic              out_v;
    logic              data_ok;

    zbt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .sleep   (sleep),
        .burst_il(burst_il),
        .chip_en (chip_en),
        .adv     (adv),
        .wr_en   (wr_en),
        .addr    (addr),
        .op_kind (op_kind),
        .op_addr (op_addr)
    );

    // command stages: s1 = issued last edge, s2 = the edge before
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind <= OP_IDLE;
            s2_kind <= OP_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_bwe  <= '0;
            s2_bwe  <= '0;
        end else begin
            s1_kind <= op_kind;
            s1_addr <= op_addr;
            s1_bwe  <= byte_we;
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
            s2_bwe  <= s1_bwe;
        end
    end

    // late write: two edges in pipelined mode, one in flow-through
    always_comb begin
        if (pipe_mode) begin
            commit      = (s2_kind == OP_WRITE);
            commit_addr = s2_addr;
            commit_bwe  = s2_bwe;
        end else begin
            commit      = (s1_kind == OP_WRITE);
            commit_addr = s1_addr;
            commit_bwe  = s1_bwe;
        end
    end

    zbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk    (clk),
        .rst    (rst),
        .wr_go  (commit),
        .wr_addr(commit_addr),
        .wr_bwe (commit_bwe),
        .wr_data(wdata),
        .rd_addr(s1_addr),
        .rd_word(rd_word),
        .rd_fwd (rd_fwd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            out_v <= 1'b0;
        end else begin
            out_q <= rd_fwd;
            out_v <= (s1_kind == OP_READ);
        end
    end

    assign data_ok = pipe_mode ? out_v : (s1_kind == OP_READ);
    assign dq_out  = pipe_mode ? out_q : rd_word;
    assign dq_oe   = data_ok && out_en && !sleep;

    logic rd_iss;
    assign rd_iss = !rst && (op_kind == OP_READ);

    AST_FLOW_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && out_en && !sleep) |-> (dq_oe == $past(rd_iss))) // R2
        else $error("flow-through read drive timing wrong");

    AST_PIPE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && out_en && !sleep) |-> (dq_oe == $past(rd_iss, 2))) // R3
        else $error("pipelined read drive timing wrong");

endmodule

// File: tb/sim_zbt_sram_core.sv
`timescale 1ns/1ps
module sim_zbt_sram_core;

    localparam int AW = 5;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst, pipe_mode, burst_il, sleep, out_en, adv, wr_en;
    logic [2:0]    chip_en;
    logic [AW-1:0] addr;
    logic [NB-1:0] byte_we;
    logic [DW-1:0] wdata, dq_out;
    logic          dq_oe;

    always #2.5 clk = ~clk;

    zbt_sram_core #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) u0 (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_il(burst_il),
        .sleep(sleep), .out_en(out_en), .chip_en(chip_en), .adv(adv),
        .wr_en(wr_en), .addr(addr), .byte_we(byte_we), .wdata(wdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // requirement-level model
    logic [DW-1:0] mm [DEPTH];
    bit            b_act;
    int            b_kind;          // 0 none, 1 read, 2 write
    logic [AW-1:0] b_base;
    logic [1:0]    b_beat;
    int            hk1, hk2;
    logic [AW-1:0] ha1, ha2;
    logic [NB-1:0] hb1, hb2;
    string         ht1, ht2;

    function automatic logic [1:0] seq_lo(logic [1:0] s, logic [1:0] n, bit il);
        return il ? (s ^ n) : 2'(s + n);
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) if (m[b]) r[b*BW +: BW] = nw[b*BW +: BW];
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] t = {$urandom, $urandom};
        return t[DW-1:0];
    endfunction

    task automatic check(string tag, logic exp_oe, logic [DW-1:0] exp_d);
        checks++;
        if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp_d)) begin
            errors++;
            $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
                     tag, dq_oe, dq_out, exp_oe, exp_d);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        b_act = 0; b_kind = 0; b_base = '0; b_beat = '0;
        hk1 = 0; hk2 = 0; ha1 = '0; ha2 = '0; hb1 = '0; hb2 = '0;
        ht1 = "R12"; ht2 = "R12";
    endtask

    task automatic cyc(string tag, logic [2:0] ce, logic a_dv, logic we, logic [AW-1:0] a,
                       logic [NB-1:0] bwe, logic [DW-1:0] wd, logic oe, logic slp);
        int            k;
        int            rk;
        logic [AW-1:0] oa, ra;
        string         rt;
        logic          eo;
        chip_en = ce; adv = a_dv; wr_en = we; addr = a; byte_we = bwe;
        wdata = wd; out_en = oe; sleep = slp;
        @(posedge clk);
        k = 0; oa = '0;
        if (!slp && a_dv && b_act) begin
            b_beat = 2'(b_beat + 1);
            k  = b_kind;
            oa = {b_base[AW-1:2], seq_lo(b_base[1:0], b_beat, burst_il)};
        end else if (!slp && !a_dv && (&ce)) begin
            k = we ? 2 : 1; oa = a;
            b_act = 1; b_base = a; b_beat = '0; b_kind = k;
        end else if (!slp && !a_dv) begin
            b_act = 0;
        end
        if (pipe_mode) begin
            if (hk2 == 2) mm[ha2] = merge(mm[ha2], wd, hb2);
        end else begin
            if (hk1 == 2) mm[ha1] = merge(mm[ha1], wd, hb1);
        end
        hk2 = hk1; ha2 = ha1; hb2 = hb1; ht2 = ht1;
        hk1 = k;   ha1 = oa;  hb1 = bwe; ht1 = tag;
        #1;
        if (pipe_mode) begin rk = hk2; ra = ha2; rt = ht2; end
        else           begin rk = hk1; ra = ha1; rt = ht1; end
        eo = (rk == 1) && oe && !slp;
        check(eo ? rt : tag, eo, mm[ra]);
        @(negedge clk);
    endtask

    task automatic go(string tag, logic [2:0] ce, logic a_dv, logic we, logic [AW-1:0] a,
                      logic [NB-1:0] bwe, logic [DW-1:0] wd);
        cyc(tag, ce, a_dv, we, a, bwe, wd, 1'b1, 1'b0);
    endtask

    task automatic do_reset(logic pm, logic il);
        @(negedge clk);
        pipe_mode = pm; burst_il = il; rst = 1'b1;
        chip_en = '0; adv = 0; wr_en = 0; addr = '0; byte_we = '0;
        wdata = '0; out_en = 1; sleep = 0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        #1 check("R12", 1'b0, '0);
    endtask

    task automatic run_random(int n, logic pm, logic il);
        string tg;
        do_reset(pm, il);
        tg = pm ? "R3" : "R2";
        for (int i = 0; i < n; i++) begin
            logic [2:0] ce  = ($urandom_range(0, 9) < 8) ? 3'b111 : 3'($urandom);
            logic       av  = ($urandom_range(0, 3) == 0);
            logic       oe  = ($urandom_range(0, 9) != 0);
            logic       sl  = ($urandom_range(0, 19) == 0);
            cyc(tg, ce, av, 1'($urandom), AW'($urandom), NB'($urandom), rnd_word(), oe, sl);
        end
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;

        // ---------- flow-through, linear ----------
        do_reset(1'b0, 1'b0);
        go("R12", 3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R12", 3'b111, 0, 0, 5'd7, 4'h0, '0);
        go("R4",  3'b111, 0, 1, 5'd3, 4'hF, '0);
        go("R4",  3'b111, 0, 0, 5'd3, 4'h0, 36'h1_2345_6789);
        go("R5",  3'b111, 0, 1, 5'd9, 4'hF, '0);
        go("R5",  3'b111, 0, 1, 5'd9, 4'b0101, 36'h9_8765_4321);
        go("R5",  3'b111, 0, 0, 5'd9, 4'h0, 36'h0);
        go("R6",  3'b111, 0, 1, 5'd6, 4'hF, '0);
        go("R6",  3'b000, 1, 0, 5'd0, 4'hF, 36'hA_0000_0001);
        go("R6",  3'b000, 1, 0, 5'd0, 4'hF, 36'hA_0000_0002);
        go("R6",  3'b000, 1, 0, 5'd0, 4'hF, 36'hA_0000_0003);
        go("R6",  3'b111, 0, 0, 5'd6, 4'h0, 36'hA_0000_0004);
        for (int i = 0; i < 3; i++) go("R6", 3'b000, 1, 0, 5'd0, 4'h0, '0);
        go("R8",  3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R8",  3'b000, 1, 0, 5'd0, 4'h0, '0);
        go("R1",  3'b011, 0, 0, 5'd3, 4'h0, '0);
        go("R1",  3'b101, 0, 1, 5'd3, 4'hF, '0);
        go("R1",  3'b110, 0, 0, 5'd3, 4'h0, 36'hF_FFFF_FFFF);
        go("R1",  3'b111, 0, 0, 5'd3, 4'h0, '0);
        cyc("R11", 3'b111, 0, 1, 5'd3, 4'hF, '0, 1'b1, 1'b1);
        cyc("R11", 3'b111, 0, 0, 5'd3, 4'h0, 36'h5_5555_5555, 1'b1, 1'b1);
        go("R11", 3'b111, 0, 0, 5'd3, 4'h0, '0);
        cyc("R10", 3'b111, 0, 0, 5'd3, 4'h0, '0, 1'b0, 1'b0);
        go("R10", 3'b000, 0, 0, 5'd0, 4'h0, '0);

        // ---------- pipelined, interleaved ----------
        do_reset(1'b1, 1'b1);
        go("R3",  3'b111, 0, 1, 5'd5, 4'hF, '0);
        go("R3",  3'b000, 0, 0, 5'd0, 4'h0, 36'h0);
        go("R3",  3'b000, 0, 0, 5'd0, 4'h0, 36'h3_CAFE_0055);
        go("R3",  3'b111, 0, 0, 5'd5, 4'h0, '0);
        go("R3",  3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R3",  3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R9",  3'b111, 0, 1, 5'd12, 4'hF, '0);
        go("R9",  3'b111, 0, 0, 5'd12, 4'h0, '0);
        go("R9",  3'b000, 0, 0, 5'd0, 4'h0, 36'h7_1111_2222);
        go("R9",  3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R9",  3'b111, 0, 1, 5'd12, 4'b0011, '0);
        go("R9",  3'b111, 0, 0, 5'd12, 4'h0, '0);
        go("R9",  3'b000, 0, 0, 5'd0, 4'h0, 36'hE_EEEE_EEEE);
        go("R9",  3'b000, 0, 0, 5'd0, 4'h0, '0);
        go("R7",  3'b111, 0, 1, 5'd5, 4'hF, '0);
        go("R7",  3'b000, 1, 0, 5'd0, 4'hF, '0);
        go("R7",  3'b000, 1, 0, 5'd0, 4'hF, 36'hB_0000_0010);
        go("R7",  3'b000, 1, 0, 5'd0, 4'hF, 36'hB_0000_0011);
        go("R7",  3'b111, 0, 0, 5'd5, 4'h0, 36'hB_0000_0012);
        go("R7",  3'b000, 1, 0, 5'd0, 4'h0, 36'hB_0000_0013);
        for (int i = 0; i < 4; i++) go("R7", 3'b000, 1, 0, 5'd0, 4'h0, '0);
        go("R13", 3'b111, 0, 1, 5'd1, 4'hF, '0);
        go("R13", 3'b111, 0, 0, 5'd2, 4'h0, '0);
        go("R13", 3'b111, 0, 1, 5'd2, 4'hF, 36'h1_0101_0101);
        go("R13", 3'b111, 0, 0, 5'd1, 4'h0, '0);
        go("R13", 3'b111, 0, 1, 5'd1, 4'hF, 36'h2_0202_0202);
        go("R13", 3'b111, 0, 0, 5'd2, 4'h0, '0);
        go("R13", 3'b111, 0, 0, 5'd1, 4'h0, 36'h3_0303_0303);
        for (int i = 0; i < 3; i++) go("R13", 3'b000, 0, 0, 5'd0, 4'h0, '0);

        // ---------- random mixes ----------
        run_random(3000, 1'b0, 1'b0);
        run_random(3000, 1'b1, 1'b1);
        run_random(3000, 1'b0, 1'b1);
        run_random(3000, 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule